// File: doc/BRIEF.md
# Priority Interrupt Controller with Claim and Complete

This block collects level interrupt requests from a set of numbered sources and presents one interrupt line to a single processor context. Each request is latched into a pending bit. Software gives each source a 3-bit priority, enables sources in groups of 32, and sets a global threshold. The controller keeps a current winner at all times. That winner is the enabled pending source whose priority is strictly above the threshold and above every other candidate. The winner's ID is shown on an output, and the interrupt line is high whenever the ID is non-zero.

Software reads the claim register to take the winner. The read returns the ID, clears that source's pending bit and marks the source as in service. While a source is in service, new requests from it are dropped. Writing the ID back to the same register completes the service, and the source can then raise a new request.

Selection looks at only one candidate per 32-bit pending word: the lowest-numbered pending source in that word. If that source is not enabled, the word offers no candidate at all. Source 0 is never a real source and stands for "no interrupt".

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source n holds pending bit n%32 of pending word n/32. Enable word w at word address 0x100+w enables sources 32w to 32w+31, with bit b standing for source 32w+b. A high request sets the pending bit, and the bit stays set after the request drops until the source is claimed.
- R2: A request from a source that is in service (claimed and not yet completed) is dropped, so its pending bit stays clear.
- R3: In each pending word, only the lowest set bit is a candidate. A higher-priority source in the same word is hidden while a lower-numbered source in that word is pending.
- R4: Words are scanned in ascending order. A candidate replaces the running best only when its priority is strictly greater. The running best starts at the threshold, so on a tie the lower-numbered candidate wins.
- R5: When no candidate is strictly above the threshold, irq_o is low and irq_id_o is 0. A priority of 0 can never win.
- R6: A read of the claim register (word address 0x141) returns the current winner's ID in bus_rdata_o on the next cycle. In the same cycle it clears that source's pending bit and sets its in-service bit, and the winner is then chosen again from what is left.
- R7: A write of an ID to the claim register clears that source's in-service bit. After that, a new request from the source is latched again.
- R8: The priority of source n is at word address n-1. A write keeps only the low 3 bits, and a read returns them.
- R9: Writes to priority, enable or threshold registers change irq_o and irq_id_o in the cycle right after the write.
- R10: After reset, every priority, enable bit, pending bit, in-service bit and the threshold are 0, and irq_o is low.
- R11: A source whose enable bit is 0 never wins, even when it is pending.
- R12: A claim read when no source qualifies returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | NUM_SRC-1 | Level requests for sources 1 to NUM_SRC-1 (bit index = source ID) |
| bus_valid_i | input | 1 | Bus access strobe, one cycle per access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle after the read strobe |
| irq_o | output | 1 | Interrupt to the core |
| irq_id_o | output | ID_W | Current winner's ID, 0 when none |

## Verification
Vectors set each source's priority to its ID modulo 8 and then raise chosen sets of requests. A single request shows the basic path. Two requests in the same word, where the higher-numbered one has the higher priority, show that only the lowest bit of a word counts. Requests spread across words show that priorities are compared between words. Equal priorities in two words show that ties go to the lower ID. Thresholds at and just below a source's priority show the strict comparison. A disabled lowest bit shows that the whole word is skipped. Directed sequences then run claim, a request during service, an empty claim and completion in order, and write priority, enable and threshold registers to check the change in the next cycle.

// File: rtl/irq_pkg.sv
// Package: shared constants and helpers for the priority interrupt controller.
// Assumes pending and enable state are grouped in 32-bit words.
package irq_pkg;
    localparam int WORD_W = 32;
    localparam int BIT_W  = 5;

    // Index of the least significant set bit; 0 when the word is empty.
    function automatic logic [BIT_W-1:0] lowest_bit(input logic [WORD_W-1:0] v);
        logic [BIT_W-1:0] r;
        r = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (v[i]) r = BIT_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_src_state.sv
// Module: keeps the pending and in-service bit of every source.
// Assumes bit 0 (the "no interrupt" ID) is never set. A claim overrides a
// request or completion for the same source in the same cycle.
module irq_src_state #(
    parameter int NUM_SRC = 64,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:1] req_i,
    input  logic               take_en_i,
    input  logic [ID_W-1:0]    take_id_i,
    input  logic               done_en_i,
    input  logic [ID_W-1:0]    done_id_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] busy_o
);
    // Per-source update: latch requests, claim and complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= '0;
            busy_o <= '0;
        end else begin
            for (int n = 1; n < NUM_SRC; n++) begin
                if (take_en_i && take_id_i == ID_W'(n)) begin
                    pend_o[n] <= 1'b0;
                    busy_o[n] <= 1'b1;
                end else begin
                    if (req_i[n] && !busy_o[n]) pend_o[n] <= 1'b1;
                    if (done_en_i && done_id_i == ID_W'(n)) busy_o[n] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/irq_pick.sv
// Module: combinational winner selection.
// Each pending word offers its lowest set bit, and only if that bit is enabled.
// Words are scanned in ascending order against a running maximum that
// starts at the threshold. A strictly greater priority replaces it.
module irq_pick #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 3,
    localparam int ID_W   = $clog2(NUM_SRC),
    localparam int NWORDS = NUM_SRC / irq_pkg::WORD_W
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0]             en_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]              thr_i,
    output logic [ID_W-1:0]                best_id_o,
    output logic                           best_vld_o
);
    import irq_pkg::*;

    logic [NWORDS-1:0]             cand_vld;
    logic [NWORDS-1:0][ID_W-1:0]   cand_id;
    logic [NWORDS-1:0][PRIO_W-1:0] cand_prio;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [BIT_W-1:0] idx;
        // Lowest pending bit of this word is its only candidate.
        assign idx          = lowest_bit(pend_i[w*WORD_W +: WORD_W]);
        assign cand_vld[w]  = (|pend_i[w*WORD_W +: WORD_W]) && en_i[w*WORD_W + int'(idx)];
        assign cand_id[w]   = ID_W'(w*WORD_W) + ID_W'(idx);
        assign cand_prio[w] = prio_i[w*WORD_W + int'(idx)];
    end

    // Ascending scan with a strict-greater running maximum.
    always_comb begin
        logic [PRIO_W-1:0] run;
        run        = thr_i;
        best_id_o  = '0;
        best_vld_o = 1'b0;
        for (int w = 0; w < NWORDS; w++) begin
            if (cand_vld[w] && cand_prio[w] > run) begin
                run        = cand_prio[w];
                best_id_o  = cand_id[w];
                best_vld_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the priority interrupt controller. It decodes the register
// bus, holds priority, enable and threshold state, and wires together the
// source state and the selector. Assumes NUM_SRC is a multiple of 32 and a
// power of two, and that the bus makes at most one access per cycle.
module prio_irq_ctrl #(
    parameter int NUM_SRC  = 64,
    parameter int PRIO_W   = 3,
    parameter int ADDR_W   = 9,
    parameter int ENA_BASE = 'h100,
    parameter int THR_ADDR = 'h140,
    parameter int CLM_ADDR = 'h141,
    localparam int ID_W    = $clog2(NUM_SRC),
    localparam int NWORDS  = NUM_SRC / irq_pkg::WORD_W,
    localparam int WIDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:1] src_req_i,
    input  logic               bus_valid_i,
    input  logic               bus_write_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               irq_o,
    output logic [ID_W-1:0]    irq_id_o
);
    import irq_pkg::*;

    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_SRC-1:0]             en_q;
    logic [PRIO_W-1:0]              thr_q;
    logic [NUM_SRC-1:0]             pend_q;
    logic [NUM_SRC-1:0]             claimed_q;

    logic              wr, rd, prio_hit, ena_hit, thr_hit, clm_hit;
    logic [ID_W-1:0]   prio_src;
    logic [WIDX_W-1:0] widx;
    logic [31:0]       rd_val;
    logic              take_en, done_en;

    // Address decode for the three register groups and the claim register.
    assign wr       = bus_valid_i && bus_write_i;
    assign rd       = bus_valid_i && !bus_write_i;
    assign prio_hit = bus_addr_i < ADDR_W'(NUM_SRC - 1);
    assign ena_hit  = bus_addr_i >= ADDR_W'(ENA_BASE) && bus_addr_i < ADDR_W'(ENA_BASE + NWORDS);
    assign thr_hit  = bus_addr_i == ADDR_W'(THR_ADDR);
    assign clm_hit  = bus_addr_i == ADDR_W'(CLM_ADDR);
    assign prio_src = ID_W'(bus_addr_i + ADDR_W'(1));
    assign widx     = WIDX_W'(bus_addr_i - ADDR_W'(ENA_BASE));
    assign take_en  = rd && clm_hit && irq_o;
    assign done_en  = wr && clm_hit;

    // Configuration registers: priorities (low bits only), enables, threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (wr) begin
            if (prio_hit) begin
                for (int n = 1; n < NUM_SRC; n++) begin
                    if (prio_src == ID_W'(n)) prio_q[n] <= bus_wdata_i[PRIO_W-1:0];
                end
            end
            if (ena_hit) begin
                for (int w = 0; w < NWORDS; w++) begin
                    if (widx == WIDX_W'(w)) en_q[w*WORD_W +: WORD_W] <= bus_wdata_i;
                end
            end
            if (thr_hit) thr_q <= bus_wdata_i[PRIO_W-1:0];
        end
    end

    // Read data selection; the claim register returns the current winner.
    always_comb begin
        rd_val = '0;
        if (prio_hit)     rd_val = 32'(prio_q[prio_src]);
        else if (ena_hit) rd_val = en_q[int'(widx)*WORD_W +: WORD_W];
        else if (thr_hit) rd_val = 32'(thr_q);
        else if (clm_hit) rd_val = 32'(irq_id_o);
    end

    // Registered read data, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata_o <= '0;
        else if (rd) bus_rdata_o <= rd_val;
    end

    irq_src_state #(.NUM_SRC(NUM_SRC)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (src_req_i),
        .take_en_i (take_en),
        .take_id_i (irq_id_o),
        .done_en_i (done_en),
        .done_id_i (bus_wdata_i[ID_W-1:0]),
        .pend_o    (pend_q),
        .busy_o    (claimed_q)
    );

    irq_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
        .pend_i     (pend_q),
        .en_i       (en_q),
        .prio_i     (prio_q),
        .thr_i      (thr_q),
        .best_id_o  (irq_id_o),
        .best_vld_o (irq_o)
    );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Checker: timing properties of the interrupt controller, bound to its top.
// Assumes the same parameters as the bound instance.
module prio_irq_ctrl_chk #(
    parameter int NUM_SRC  = 64,
    parameter int PRIO_W   = 3,
    parameter int ADDR_W   = 9,
    parameter int CLM_ADDR = 'h141,
    localparam int ID_W    = $clog2(NUM_SRC)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_valid_i,
    input logic                           bus_write_i,
    input logic [ADDR_W-1:0]              bus_addr_i,
    input logic [31:0]                    bus_rdata_o,
    input logic                           irq_o,
    input logic [ID_W-1:0]                irq_id_o,
    input logic [NUM_SRC-1:0]             pend_q,
    input logic [NUM_SRC-1:0]             claimed_q,
    input logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q,
    input logic [PRIO_W-1:0]              thr_q
);
    logic clm_rd;
    assign clm_rd = bus_valid_i && !bus_write_i && bus_addr_i == ADDR_W'(CLM_ADDR);

    // R2
    pend_claimed_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & claimed_q) == '0);

    // R4
    win_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> prio_q[irq_id_o] > thr_q);

    // R5
    idle_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> irq_id_o == '0);

    // R6
    claim_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clm_rd |=> bus_rdata_o == 32'($past(irq_id_o)));

    // R6
    claim_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clm_rd && irq_o) |=> claimed_q[$past(irq_id_o)] && !pend_q[$past(irq_id_o)]);

    // R10
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o && pend_q == '0);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .CLM_ADDR(CLM_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .irq_id_o    (irq_id_o),
    .pend_q      (pend_q),
    .claimed_q   (claimed_q),
    .prio_q      (prio_q),
    .thr_q       (thr_q)
);

// File: tb/prio_irq_ctrl_bench.sv
// Bench: vector table with priority = ID mod 8, then directed sequences.
module prio_irq_ctrl_bench;
    localparam int NSRC = 64;
    localparam int IDW  = 6;
    localparam logic [8:0] ENA0 = 9'h100;
    localparam logic [8:0] ENA1 = 9'h101;
    localparam logic [8:0] THR  = 9'h140;
    localparam logic [8:0] CLM  = 9'h141;

    typedef struct packed {
        logic [63:0] req;
        logic [63:0] en;
        logic [2:0]  thr;
        logic [5:0]  id;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{64'h20,                  64'hFFFFFFFF_FFFFFFFF, 3'd0, 6'd5},   // R1 single
        '{64'h48,                  64'hFFFFFFFF_FFFFFFFF, 3'd0, 6'd3},   // R3 same word
        '{64'h00000040_00000008,   64'hFFFFFFFF_FFFFFFFF, 3'd0, 6'd38},  // R4 across words
        '{64'h00000080_00000080,   64'hFFFFFFFF_FFFFFFFF, 3'd0, 6'd7},   // R4 tie
        '{64'h20,                  64'hFFFFFFFF_FFFFFFFF, 3'd5, 6'd0},   // R5 equal thr
        '{64'h20,                  64'hFFFFFFFF_FFFFFFFF, 3'd4, 6'd5},   // R4 just above
        '{64'h00000010_00000014,   64'hFFFFFFFF_FFFFFFFB, 3'd0, 6'd36},  // R11 word skipped
        '{64'h100,                 64'hFFFFFFFF_FFFFFFFF, 3'd0, 6'd0},   // R5 prio 0
        '{64'h00000200_00000200,   64'hFFFFFFFF_FFFFFFFF, 3'd0, 6'd9},   // R4 tie low
        '{64'h00008000_00008000,   64'hFFFFFFFF_FFFFFFFF, 3'd0, 6'd15}   // R4 tie max
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:1] src_req = '0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [8:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq;
    logic [IDW-1:0]  irq_id;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req_i   (src_req),
        .bus_valid_i (bus_valid),
        .bus_write_i (bus_write),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq),
        .irq_id_o    (irq_id)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [8:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [63:0] m);
        src_req = m[63:1];
        @(negedge clk);
        src_req = '0;
    endtask

    task automatic check_out(input string tag, input logic [5:0] id);
        check({tag, " irq"}, 32'(irq), 32'(id != 0));
        check({tag, " id"}, 32'(irq_id), 32'(id));
    endtask

    initial begin
        logic [31:0] rv;
        @(negedge clk);
        do_reset();

        // R10 reset state seen at the ports
        check("R10 irq", 32'(irq), 32'd0);
        bus_rd(THR, rv);      check("R10 thr", rv, 32'd0);
        bus_rd(9'd4, rv);     check("R10 prio", rv, 32'd0);
        bus_rd(ENA0, rv);     check("R10 en", rv, 32'd0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            do_reset();
            for (int s = 1; s < NSRC; s++) bus_wr(9'(s - 1), 32'(s % 8));
            bus_wr(ENA0, VECS[v].en[31:0]);
            bus_wr(ENA1, VECS[v].en[63:32]);
            bus_wr(THR, 32'(VECS[v].thr));
            pulse(VECS[v].req);
            check_out($sformatf("R3/R4/R5 vec%0d", v), VECS[v].id);
        end

        // R8 address map and 3-bit storage
        do_reset();
        bus_wr(9'd4, 32'hFF);
        bus_rd(9'd4, rv);     check("R8 readback", rv, 32'd7);
        bus_wr(ENA0, 32'hFFFFFFFF);
        pulse(64'h20);
        check_out("R8 src5", 6'd5);

        // R6 claim
        bus_rd(CLM, rv);      check("R6 claim id", rv, 32'd5);
        check_out("R6 after claim", 6'd0);
        // R2 request while in service is dropped
        pulse(64'h20);
        check_out("R2 drop", 6'd0);
        // R12 empty claim
        bus_rd(CLM, rv);      check("R12 empty", rv, 32'd0);
        check_out("R12 no change", 6'd0);
        // R7 complete, then a new request latches
        bus_wr(CLM, 32'd5);
        check_out("R7 still idle", 6'd0);
        pulse(64'h20);
        check_out("R7 relatch", 6'd5);

        // R9 immediate effect of configuration writes
        bus_wr(THR, 32'd7);   check_out("R9 thr up", 6'd0);
        bus_wr(THR, 32'd0);   check_out("R9 thr down", 6'd5);
        bus_wr(9'd4, 32'd0);  check_out("R9 prio zero", 6'd0);
        bus_wr(9'd4, 32'd4);  check_out("R9 prio set", 6'd5);
        bus_wr(ENA0, 32'd0);  check_out("R11 disabled", 6'd0);

        // R1 second word mapping
        bus_wr(ENA1, 32'h20);
        bus_wr(9'd36, 32'd2);
        pulse(64'h20_00000000);
        check_out("R1 src37", 6'd37);

        // R6 re-selection after claim
        do_reset();
        bus_wr(9'd2, 32'd3);
        bus_wr(9'd37, 32'd6);
        bus_wr(ENA0, 32'hFFFFFFFF);
        bus_wr(ENA1, 32'hFFFFFFFF);
        pulse(64'h00000040_00000008);
        check_out("R6 first", 6'd38);
        bus_rd(CLM, rv);      check("R6 claim 38", rv, 32'd38);
        check_out("R6 next", 6'd3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule